// File: doc/BRIEF.md
# Ping-pong receive buffer for a USB device OUT endpoint

This block holds the data that a USB host sends to one OUT endpoint of a device. Two banks alternate. The packet side writes a byte stream into whichever bank software does not currently own. Marking the last byte commits that bank as full. The software side is a small register window with a status register, a write-one control register, an interrupt enable and a byte-wide data port. Software reads a bank's bytes in order through the data port.

Two flags track the bank that software currently owns, and they are kept apart. The received-data flag is the interrupt source, and software acknowledges it on its own. The bank-held flag means the owned bank is full and not yet given back. Acknowledging the interrupt leaves the buffer untouched. Giving the bank back frees it, moves the read side to the next bank, and reloads both flags from that bank's state. An endpoint reset empties everything and returns both pointers to bank 0.

Top module: `usb_out_ep_buf`

## Requirements
- R1: When a packet commit fills the bank that software owns, the received-data flag (STATUS bit 0) and the bank-held flag (STATUS bit 1) both become one on the same clock edge. The STATUS register is at address 0.
- R2: `irq` is high exactly when the received-data flag is one and the interrupt enable is one. The interrupt enable is bit 0 of the register at address 2.
- R3: Writing one to CTRL bit 0 clears the received-data flag. CTRL is at address 1. This write leaves the bank-held flag, the read-allowed flag, the bank pointer and the next data byte unchanged.
- R4: Writing one to CTRL bit 1 while the bank-held flag is set frees the owned bank and moves software to the next bank. The busy-bank count in STATUS bits 5:4 drops by one.
- R5: After a bank switch, both flags are reloaded from the new bank. Both are one at once if that bank is already full, and both are zero otherwise. When bits 0 and 1 are written together, the clear takes effect first.
- R6: The read-allowed flag (STATUS bit 2) is one while the owned bank still holds unread bytes. A read of address 3 returns the next byte in arrival order, and a read strobe there advances to the following byte.
- R7: While `cfg_en` is low, packet bytes and commits are ignored, and no bank changes state.
- R8: `pkt_busy` is high when every bank is full. Bytes offered in that state are dropped. STATUS bits 5:4 give the number of full banks, from 0 to 2.
- R9: Releasing a bank while the received-data flag is still set, without clearing it in the same write, sets a sticky ordering-error flag (STATUS bit 3). The bank is still released. Writing one to CTRL bit 2 clears the error flag.
- R10: A one-cycle pulse on `ep_rst` empties both banks, clears the received-data flag, the bank-held flag and the error flag, and returns both pointers to bank 0.
- R11: A bank keeps at most 64 bytes of a packet. Further bytes of that packet are dropped, and the packet still commits on its last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Endpoint configured and enabled |
| ep_rst | input | 1 | Synchronous endpoint reset pulse |
| pkt_valid | input | 1 | Received byte strobe |
| pkt_data | input | 8 | Received byte |
| pkt_last | input | 1 | Marks the last byte of a packet |
| pkt_busy | output | 1 | All banks full; the host would be NAKed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances the data port) |
| reg_addr | input | 2 | 0 STATUS, 1 CTRL, 2 IENABLE, 3 DATA |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Endpoint interrupt |

## Verification
The bench uses the default parameters: two banks of 64 bytes. With these values a 70-byte packet exercises truncation. Three packets in a row exercise the all-banks-full state, including the dropped third packet. A release-with-clear in a single write shows the flags reloading from an already-full second bank. A scoreboard queue holds the expected bytes in host order and compares them with every data-port read, which also exposes any byte that leaked in while the endpoint was disabled or busy.

// File: rtl/usbout_pkg.sv
package usbout_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_CTRL   = 2'd1,
        RA_IEN    = 2'd2,
        RA_DATA   = 2'd3
    } reg_addr_e;

    // control register write-one bits
    localparam int CB_CLR_RX  = 0;
    localparam int CB_RELEASE = 1;
    localparam int CB_CLR_ERR = 2;

    typedef struct packed {
        logic [1:0] spare;
        logic [1:0] nbusy;
        logic       order_err;
        logic       rd_allow;
        logic       bank_held;
        logic       rx_flag;
    } status_t;

    function automatic logic is_addr(input logic [1:0] a, input reg_addr_e r);
        return a == r;
    endfunction
endpackage

// File: rtl/usbout_bank.sv
module usbout_bank #(
    parameter int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [usbout_pkg::BYTE_W-1:0] wr_data,
    input  logic                      commit,
    input  logic                      free,
    input  logic [AW-1:0]             rd_addr,
    output logic                      full,
    output logic [CW-1:0]             cnt,
    output logic [usbout_pkg::BYTE_W-1:0] rd_data
);
    logic [usbout_pkg::BYTE_W-1:0] mem [DEPTH];
    logic room;

    assign room    = (cnt < CW'(DEPTH)) && !full;
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en && room) mem[cnt[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (clr || free) begin
            full <= 1'b0;
            cnt  <= '0;
        end else begin
            if (wr_en && room) cnt <= cnt + 1'b1;
            if (commit && !full) full <= 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (clr)
        cnt <= CW'(DEPTH)) else $error("count over depth"); // R11
endmodule

// File: rtl/usbout_ctrl.sv
module usbout_ctrl
    import usbout_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int DEPTH = 64,
    localparam int PW   = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(NBANK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             ep_rst,
    input  logic             pkt_valid,
    input  logic             pkt_last,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [NBANK-1:0] full,
    input  logic [CW-1:0]    rd_cnt,
    output logic [NBANK-1:0] wr_en_v,
    output logic [NBANK-1:0] commit_v,
    output logic [NBANK-1:0] free_v,
    output logic [PW-1:0]    rd_ptr,
    output logic [CW-1:0]    rd_idx,
    output status_t          status,
    output logic             ien,
    output logic             irq,
    output logic             pkt_busy
);
    logic [PW-1:0] wr_ptr, nxt_ptr;
    logic rx_flag, bank_held, order_err;
    logic accept, ctl_wr, clr_rx, rel, clr_err, rd_ok, data_rd, nxt_full;
    logic unused_ok;

    assign unused_ok = &{1'b0, reg_wdata[BYTE_W-1:3]};

    assign nxt_ptr  = (rd_ptr == PW'(NBANK - 1)) ? '0 : rd_ptr + 1'b1;
    assign pkt_busy = full[wr_ptr];
    assign accept   = cfg_en && pkt_valid && !full[wr_ptr] && !ep_rst;
    assign wr_en_v  = NBANK'(accept) << wr_ptr;
    assign commit_v = NBANK'(accept && pkt_last) << wr_ptr;

    assign ctl_wr   = reg_wr && is_addr(reg_addr, RA_CTRL) && !ep_rst;
    assign clr_rx   = ctl_wr && reg_wdata[CB_CLR_RX];
    assign rel      = ctl_wr && reg_wdata[CB_RELEASE] && bank_held;
    assign clr_err  = ctl_wr && reg_wdata[CB_CLR_ERR];
    assign free_v   = NBANK'(rel) << rd_ptr;
    assign nxt_full = full[nxt_ptr] || commit_v[nxt_ptr];

    assign rd_ok    = bank_held && (rd_idx < rd_cnt);
    assign data_rd  = reg_rd && is_addr(reg_addr, RA_DATA) && rd_ok;
    assign irq      = rx_flag && ien;

    always_comb begin
        status           = '0;
        status.rx_flag   = rx_flag;
        status.bank_held = bank_held;
        status.rd_allow  = rd_ok;
        status.order_err = order_err;
        status.nbusy     = 2'($countones(full));
    end

    always_ff @(posedge clk) begin
        if (rst) ien <= 1'b0;
        else if (reg_wr && is_addr(reg_addr, RA_IEN)) ien <= reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst || ep_rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            rd_idx    <= '0;
            rx_flag   <= 1'b0;
            bank_held <= 1'b0;
            order_err <= 1'b0;
        end else begin
            if (accept && pkt_last)
                wr_ptr <= (wr_ptr == PW'(NBANK - 1)) ? '0 : wr_ptr + 1'b1;
            if (clr_err) order_err <= 1'b0;
            if (rel) begin
                rd_ptr    <= nxt_ptr;
                rd_idx    <= '0;
                rx_flag   <= nxt_full;
                bank_held <= nxt_full;
                if (rx_flag && !clr_rx) order_err <= 1'b1;
            end else begin
                if (commit_v[rd_ptr]) begin
                    rx_flag   <= 1'b1;
                    bank_held <= 1'b1;
                end else if (clr_rx) begin
                    rx_flag <= 1'b0;
                end
                if (data_rd) rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    AST_RX_NEEDS_BANK: assert property (@(posedge clk) disable iff (rst)
        rx_flag |-> bank_held) else $error("rx flag without bank"); // R1
    AST_HELD_IS_FULL: assert property (@(posedge clk) disable iff (rst || ep_rst)
        bank_held |-> full[rd_ptr]) else $error("held bank not full"); // R4
    AST_CLR_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst || ep_rst)
        (clr_rx && !rel) |=> $stable(rd_ptr)) else $error("clear moved pointer"); // R3
    AST_REL_ADVANCES: assert property (@(posedge clk) disable iff (rst || ep_rst)
        rel |=> (rd_ptr != $past(rd_ptr))) else $error("release did not switch"); // R4
    AST_EPRST_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ep_rst |=> (rd_ptr == '0 && !bank_held && !order_err)) else $error("ep reset"); // R10
    AST_BUSY_ALL_FULL: assert property (@(posedge clk) disable iff (rst)
        pkt_busy |-> ($countones(full) == NBANK)) else $error("busy early"); // R8
endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf
    import usbout_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              ep_rst,
    input  logic              pkt_valid,
    input  logic [BYTE_W-1:0] pkt_data,
    input  logic              pkt_last,
    output logic              pkt_busy,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int PW = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NBANK-1:0]  full, wr_en_v, commit_v, free_v;
    logic [CW-1:0]     cnt   [NBANK];
    logic [BYTE_W-1:0] rdat  [NBANK];
    logic [PW-1:0]     rd_ptr;
    logic [CW-1:0]     rd_idx;
    status_t           status;
    logic              ien;
    logic              bank_clr;

    assign bank_clr = rst || ep_rst;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        usbout_bank #(.DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .clr     (bank_clr),
            .wr_en   (wr_en_v[b]),
            .wr_data (pkt_data),
            .commit  (commit_v[b]),
            .free    (free_v[b]),
            .rd_addr (rd_idx[AW-1:0]),
            .full    (full[b]),
            .cnt     (cnt[b]),
            .rd_data (rdat[b])
        );
    end

    usbout_ctrl #(.NBANK(NBANK), .DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_en    (cfg_en),
        .ep_rst    (ep_rst),
        .pkt_valid (pkt_valid),
        .pkt_last  (pkt_last),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .full      (full),
        .rd_cnt    (cnt[rd_ptr]),
        .wr_en_v   (wr_en_v),
        .commit_v  (commit_v),
        .free_v    (free_v),
        .rd_ptr    (rd_ptr),
        .rd_idx    (rd_idx),
        .status    (status),
        .ien       (ien),
        .irq       (irq),
        .pkt_busy  (pkt_busy)
    );

    always_comb begin
        unique case (reg_addr)
            RA_STATUS: reg_rdata = status;
            RA_IEN:    reg_rdata = {{(BYTE_W-1){1'b0}}, ien};
            RA_DATA:   reg_rdata = status.rd_allow ? rdat[rd_ptr] : '0;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_usb_out_ep_buf.sv
module sim_usb_out_ep_buf;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst = 1'b1, cfg_en = 1'b0, ep_rst = 1'b0;
    logic pkt_valid = 1'b0, pkt_last = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] pkt_data = '0, reg_wdata = '0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_rdata;
    logic pkt_busy, irq;

    int n_run = 0, n_fail = 0;
    logic [7:0] exp_q [$];

    always #(CLK_P/2) clk = ~clk;

    usb_out_ep_buf u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .ep_rst(ep_rst),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
        .pkt_busy(pkt_busy), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic stat_chk(input string req, input int exp);
        reg_addr = 2'd0;
        #1;
        chk(req, int'(reg_rdata), exp);
    endtask

    // driver: sends a packet, pushes the bytes that must be stored
    task automatic send_pkt(input int n, input logic [7:0] base, input bit keep);
        for (int i = 0; i < n; i++) begin
            pkt_valid = 1'b1;
            pkt_data  = base + 8'(i);
            pkt_last  = (i == n - 1);
            if (keep && i < 64) exp_q.push_back(base + 8'(i));
            @(negedge clk);
        end
        pkt_valid = 1'b0; pkt_last = 1'b0;
    endtask

    // monitor: pops expected bytes and compares data-port reads
    task automatic read_n(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            reg_addr = 2'd3;
            #1;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
            chk(req, int'(reg_rdata), int'(e));
            reg_rd = 1'b1;
            @(negedge clk);
            reg_rd = 1'b0;
        end
    endtask

    task automatic drop(input int n);
        for (int i = 0; i < n; i++) void'(exp_q.pop_front());
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        stat_chk("R10 reset status", 8'h00);
        chk("R2 reset irq", int'(irq), 0);
        chk("R8 reset busy", int'(pkt_busy), 0);

        // R7: disabled endpoint ignores packets
        send_pkt(4, 8'hE0, 1'b0);
        stat_chk("R7 disabled ignored", 8'h00);

        cfg_en = 1'b1;
        reg_write(2'd2, 8'h01);
        send_pkt(5, 8'h10, 1'b1);
        stat_chk("R1 flags set on fill", 8'h17);
        chk("R2 irq with enable", int'(irq), 1);
        reg_write(2'd2, 8'h00);
        chk("R2 irq masked", int'(irq), 0);
        reg_write(2'd2, 8'h01);

        // R3: acknowledge only
        reg_write(2'd1, 8'h01);
        stat_chk("R3 clear keeps bank", 8'h16);
        chk("R3 irq dropped", int'(irq), 0);
        reg_addr = 2'd3; #1;
        chk("R3 data untouched", int'(reg_rdata), int'(exp_q[0]));

        read_n(5, "R6 ordered read");
        stat_chk("R6 read-allowed falls", 8'h12);

        // R8: fill second bank, then a dropped packet
        send_pkt(3, 8'h30, 1'b1);
        stat_chk("R8 two busy", 8'h22);
        chk("R8 busy when full", int'(pkt_busy), 1);
        send_pkt(2, 8'hC0, 1'b0);

        // R4 / R5: release to the full bank
        reg_write(2'd1, 8'h02);
        stat_chk("R5 reload from full bank", 8'h17);
        chk("R4 busy cleared", int'(pkt_busy), 0);

        // R9: release without clearing
        reg_write(2'd1, 8'h02);
        stat_chk("R9 order error, bank freed", 8'h08);
        exp_q.delete();
        reg_write(2'd1, 8'h04);
        stat_chk("R9 error cleared", 8'h00);

        // R11: oversize packet
        send_pkt(70, 8'h40, 1'b1);
        stat_chk("R11 long packet committed", 8'h17);
        read_n(64, "R11 first 64 bytes");
        stat_chk("R11 truncated at 64", 8'h13);
        reg_write(2'd1, 8'h03);
        stat_chk("R4 released", 8'h00);

        // R5: clear and release together onto a full bank
        send_pkt(2, 8'h90, 1'b1);
        stat_chk("R1 second fill", 8'h17);
        send_pkt(3, 8'hA0, 1'b1);
        stat_chk("R8 both full", 8'h27);
        reg_write(2'd1, 8'h03);
        stat_chk("R5 switch no error", 8'h17);
        drop(2);
        read_n(3, "R5 next bank data");

        // R10: endpoint reset
        ep_rst = 1'b1;
        @(negedge clk);
        ep_rst = 1'b0;
        stat_chk("R10 ep reset clears", 8'h00);
        chk("R10 irq low", int'(irq), 0);
        exp_q.delete();
        send_pkt(4, 8'h55, 1'b1);
        stat_chk("R10 usable after reset", 8'h17);
        read_n(4, "R10 data after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule